// File: doc/BRIEF.md
# Contactless Byte Interface Bridge

This block sits between a radio front end and a processor and moves single bytes in both directions. It runs on the recovered carrier clock. A free-running counter divides that clock down to a subcarrier, and every subcarrier period carries one serial bit. On the serial side, each byte is framed with one start bit and one stop bit. On the processor side, each byte passes through a four-phase request/acknowledge handshake with bundled data. The processor's handshake and direction lines are asynchronous to the bridge clock, so each one passes through a synchronizer chain before the control logic uses it.

A direction input from the processor chooses the mode. When it is high, the bridge receives: it deserializes frames from the demodulated bit stream and offers the bytes to the processor. When it is low, the bridge transmits: it accepts bytes from the processor and sends them out as BPSK modulation on a load-switch output. Both directions share one byte buffer. In receive mode, a new byte that arrives before the processor has read the previous one replaces it and sets a flag.

Top module: `cbb_bridge`

## Requirements
- R1: After reset, `wr_ack`, `rd_req`, `load_mod`, `frame_err` and `overrun` are all low.
- R2: One serial bit lasts 2^DIV_LOG2 clock cycles (16 by default). The subcarrier is the most significant bit of the divide counter: low for the first half of each bit period and high for the second half.
- R3: A transmitted frame is a start bit of value 0, then 8 data bits with the least significant bit first, then a stop bit of value 1.
- R4: While a frame is sent, `load_mod` equals the subcarrier XOR a phase bit. The phase bit is 0 before the frame and inverts at the start of every bit whose value is 0. So `load_mod` equals the phase during the first half of a bit period and its inverse during the second half. Outside a frame, `load_mod` is held low.
- R5: In transmit mode with the buffer empty, a `wr_req` seen high after the synchronizer captures `wr_data` and raises `wr_ack`. `wr_ack` falls only after `wr_req` is low and the serializer has taken the byte out of the buffer.
- R6: While `rx_en` is high, `wr_req` is ignored: `wr_ack` stays low and `load_mod` stays low.
- R7: In receive mode, a 0 sampled on the idle line starts a frame. The 8 data bits that follow are assembled least significant bit first. A stop bit of value 1 stores the byte in the buffer.
- R8: `rd_req` rises only when the buffer holds a received byte and `rd_rdy` is high, with that byte on `rd_data`. `rd_req` falls after `rd_rdy` goes low, and that completes the read and empties the buffer.
- R9: A stop bit of value 0 discards the frame: the buffer is not written and no `rd_req` follows. `frame_err` pulses high for exactly one cycle.
- R10: A byte received while the buffer still holds an unread byte overwrites it and sets `overrun`. `overrun` clears when the next read handshake completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered carrier clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Direction select from the processor: 1 receive, 0 transmit (asynchronous) |
| rx_bit | input | 1 | Demodulated serial data from the front end, idle high |
| wr_req | input | 1 | Write request from the processor (asynchronous) |
| wr_data | input | DATA_W | Byte to transmit, bundled with `wr_req` |
| wr_ack | output | 1 | Write acknowledge |
| rd_rdy | input | 1 | Processor ready to take a received byte (asynchronous) |
| rd_req | output | 1 | Received byte available |
| rd_data | output | DATA_W | Received byte, bundled with `rd_req` |
| load_mod | output | 1 | BPSK load-switch drive |
| frame_err | output | 1 | One-cycle pulse on a missing stop bit |
| overrun | output | 1 | An unread byte was overwritten |

## Verification
The bench builds the bridge with DIV_LOG2 = 2, so one bit lasts four clocks. This keeps a ten-bit frame at forty cycles. At that length, a second write handshake can finish while the first frame is still being sent, which makes the acknowledge hold-off and back-to-back framing observable. The bench decodes the modulation cycle by cycle: it takes each bit's phase from the first sample of the period and checks the inversion across the half period. DATA_W and SYNC_STAGES stay at 8 and 2.

// File: rtl/cbb_pkg.sv
package cbb_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_DATA, RX_STOP} rx_state_e;
  typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;
endpackage

// File: rtl/cbb_sync.sv
module cbb_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d};
  end

  assign q = chain_q[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/cbb_divider.sv
module cbb_divider #(
  parameter int DIV_LOG2 = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic sub,
  output logic bit_tick
);
  localparam logic [DIV_LOG2-1:0] ONE = 1;

  logic [DIV_LOG2-1:0] cnt_q, cnt_d;

  always_comb cnt_d = cnt_q + ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign sub      = cnt_q[DIV_LOG2-1];
  assign bit_tick = &cnt_q;

  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);
endmodule

// File: rtl/cbb_rx_deser.sv
module cbb_rx_deser
  import cbb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              bit_in,
  output logic              byte_valid,
  output logic [DATA_W-1:0] byte_data,
  output logic              frame_err
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] ONE  = 1;

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              valid_q, valid_d;
  logic              ferr_q, ferr_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    valid_d = 1'b0;
    ferr_d  = 1'b0;
    if (!en) begin
      state_d = RX_IDLE;
    end else if (tick) begin
      case (state_q)
        RX_IDLE: if (!bit_in) begin
          state_d = RX_DATA;
          cnt_d   = '0;
        end
        RX_DATA: begin
          sh_d = {bit_in, sh_q[DATA_W-1:1]};
          if (cnt_q == LAST) state_d = RX_STOP;
          else               cnt_d   = cnt_q + ONE;
        end
        RX_STOP: begin
          state_d = RX_IDLE;
          if (bit_in) valid_d = 1'b1;
          else        ferr_d  = 1'b1;
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      valid_q <= valid_d;
      ferr_q  <= ferr_d;
    end
  end

  assign byte_valid = valid_q;
  assign byte_data  = sh_q;
  assign frame_err  = ferr_q;

  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_q && ferr_q));
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ferr_q |=> !ferr_q);
endmodule

// File: rtl/cbb_tx_ser.sv
module cbb_tx_ser
  import cbb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              sub,
  input  logic              en,
  input  logic              full,
  input  logic [DATA_W-1:0] data_in,
  output logic              take,
  output logic              load_mod
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] ONE  = 1;

  tx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              phase_q, phase_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    phase_d = phase_q;
    take    = 1'b0;
    if (tick) begin
      case (state_q)
        TX_IDLE, TX_STOP: begin
          if (en && full) begin
            take    = 1'b1;
            sh_d    = data_in;
            state_d = TX_START;
            phase_d = 1'b1;
          end else begin
            state_d = TX_IDLE;
            phase_d = 1'b0;
          end
        end
        TX_START: begin
          state_d = TX_DATA;
          cnt_d   = '0;
          phase_d = phase_q ^ ~sh_q[0];
          sh_d    = {1'b0, sh_q[DATA_W-1:1]};
        end
        TX_DATA: begin
          if (cnt_q == LAST) begin
            state_d = TX_STOP;
          end else begin
            cnt_d   = cnt_q + ONE;
            phase_d = phase_q ^ ~sh_q[0];
            sh_d    = {1'b0, sh_q[DATA_W-1:1]};
          end
        end
        default: state_d = TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      phase_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      phase_q <= phase_d;
    end
  end

  assign load_mod = (state_q != TX_IDLE) & (sub ^ phase_q);

  assert_start_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_START) |-> phase_q);
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_IDLE) |-> !phase_q);
endmodule

// File: rtl/cbb_bridge.sv
module cbb_bridge #(
  parameter int DIV_LOG2    = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rx_bit,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ack,
  input  logic              rd_rdy,
  output logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              load_mod,
  output logic              frame_err,
  output logic              overrun
);
  logic [2:0]        ctl_s;
  logic              rx_en_s, wr_req_s, rd_rdy_s, rx_bit_s;
  logic              sub, bit_tick;
  logic              rx_valid;
  logic [DATA_W-1:0] rx_data;
  logic              tx_take, tx_en;
  logic              read_done;

  logic [DATA_W-1:0] buf_q, buf_d;
  logic              full_q, full_d;
  logic              wr_ack_q, wr_ack_d;
  logic              rd_req_q, rd_req_d;
  logic              ovr_q, ovr_d;

  cbb_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) ctl_sync_i (
    .clk(clk), .rst_n(rst_n), .d({rx_en, wr_req, rd_rdy}), .q(ctl_s));
  assign {rx_en_s, wr_req_s, rd_rdy_s} = ctl_s;

  cbb_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) line_sync_i (
    .clk(clk), .rst_n(rst_n), .d(rx_bit), .q(rx_bit_s));

  cbb_divider #(.DIV_LOG2(DIV_LOG2)) div_i (
    .clk(clk), .rst_n(rst_n), .sub(sub), .bit_tick(bit_tick));

  cbb_rx_deser #(.DATA_W(DATA_W)) rx_i (
    .clk(clk), .rst_n(rst_n), .en(rx_en_s), .tick(bit_tick), .bit_in(rx_bit_s),
    .byte_valid(rx_valid), .byte_data(rx_data), .frame_err(frame_err));

  assign tx_en = !rx_en_s && !rd_req_q;

  cbb_tx_ser #(.DATA_W(DATA_W)) tx_i (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .sub(sub), .en(tx_en),
    .full(full_q), .data_in(buf_q), .take(tx_take), .load_mod(load_mod));

  assign read_done = rd_req_q && !rd_rdy_s;

  always_comb begin
    buf_d    = buf_q;
    full_d   = full_q;
    wr_ack_d = wr_ack_q;
    rd_req_d = rd_req_q;
    ovr_d    = ovr_q;

    if (tx_take) full_d = 1'b0;

    if (!wr_ack_q) begin
      if (wr_req_s && !rx_en_s && !full_q && !rd_req_q) begin
        buf_d    = wr_data;
        full_d   = 1'b1;
        wr_ack_d = 1'b1;
      end
    end else if (!wr_req_s && !full_q) begin
      wr_ack_d = 1'b0;
    end

    if (!rd_req_q) begin
      if (full_q && rx_en_s && rd_rdy_s && !wr_ack_q) rd_req_d = 1'b1;
    end else if (read_done) begin
      rd_req_d = 1'b0;
      full_d   = 1'b0;
      ovr_d    = 1'b0;
    end

    if (rx_valid) begin
      buf_d  = rx_data;
      full_d = 1'b1;
      if (full_q && !read_done) ovr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q    <= '0;
      full_q   <= 1'b0;
      wr_ack_q <= 1'b0;
      rd_req_q <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      buf_q    <= buf_d;
      full_q   <= full_d;
      wr_ack_q <= wr_ack_d;
      rd_req_q <= rd_req_d;
      ovr_q    <= ovr_d;
    end
  end

  assign wr_ack  = wr_ack_q;
  assign rd_req  = rd_req_q;
  assign rd_data = buf_q;
  assign overrun = ovr_q;

  assert_ack_waits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack_q && full_q) |=> wr_ack_q);
  assert_no_write_in_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_ack_q) |-> !$past(rx_en_s));
  assert_req_has_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_q |-> full_q);
  assert_overrun_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(rx_valid));
endmodule

// File: tb/cbb_bridge_tb.sv
module cbb_bridge_tb_top;
  localparam int DIV_LOG2 = 2;
  localparam int BP       = 1 << DIV_LOG2;
  localparam int DATA_W   = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rx_en = 1'b0;
  logic              rx_bit = 1'b1;
  logic              wr_req = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              wr_ack;
  logic              rd_rdy = 1'b0;
  logic              rd_req;
  logic [DATA_W-1:0] rd_data;
  logic              load_mod;
  logic              frame_err;
  logic              overrun;

  int checks = 0;
  int errors = 0;
  int ferr_cnt = 0;

  always #4 clk = ~clk;

  cbb_bridge #(.DIV_LOG2(DIV_LOG2), .DATA_W(DATA_W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_bit(rx_bit),
    .wr_req(wr_req), .wr_data(wr_data), .wr_ack(wr_ack),
    .rd_rdy(rd_rdy), .rd_req(rd_req), .rd_data(rd_data),
    .load_mod(load_mod), .frame_err(frame_err), .overrun(overrun));

  always @(posedge clk) if (frame_err === 1'b1) ferr_cnt <= ferr_cnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ack(input logic val, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (wr_ack === val) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic wait_rdreq(input logic val, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (rd_req === val) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic wait_mod_high(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (load_mod === 1'b1) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  // Starts on the first cycle of a start bit; returns on the cycle after the stop bit.
  task automatic decode_frame(output logic [7:0] b, output bit start_ok,
                              output bit stop_ok, output int shape_err);
    logic prev = 1'b0;
    logic ph = 1'b0;
    logic bitv;
    shape_err = 0;
    b = '0;
    start_ok = 1'b0;
    stop_ok = 1'b0;
    for (int k = 0; k < 10; k++) begin
      for (int j = 0; j < BP; j++) begin
        if (j == 0) ph = load_mod;
        else if (load_mod !== (ph ^ ((j >= BP/2) ? 1'b1 : 1'b0))) shape_err++;
        @(negedge clk);
      end
      bitv = (ph == prev);
      prev = ph;
      if (k == 0) start_ok = (bitv == 1'b0);
      else if (k <= 8) b[k-1] = bitv;
      else stop_ok = bitv;
    end
  endtask

  task automatic send_serial(input logic [7:0] b, input logic stop);
    rx_bit = 1'b0; cycles(BP);
    for (int k = 0; k < 8; k++) begin rx_bit = b[k]; cycles(BP); end
    rx_bit = stop; cycles(BP);
    rx_bit = 1'b1;
  endtask

  task automatic t_reset;
    chk(wr_ack === 1'b0, "R1 wr_ack", wr_ack, 0);
    chk(rd_req === 1'b0, "R1 rd_req", rd_req, 0);
    chk(load_mod === 1'b0, "R1 load_mod", load_mod, 0);
    chk(frame_err === 1'b0, "R1 frame_err", frame_err, 0);
    chk(overrun === 1'b0, "R1 overrun", overrun, 0);
  endtask

  task automatic t_tx_single;
    bit ok, ok2, s_ok, p_ok; logic [7:0] b; int shape; int hi;
    rx_en = 1'b0; cycles(6);
    wr_data = 8'hA5; wr_req = 1'b1;
    wait_ack(1'b1, ok);
    chk(ok, "R5 ack rises", wr_ack, 1);
    fork
      begin
        wait_mod_high(ok2);
        decode_frame(b, s_ok, p_ok, shape);
      end
      begin
        wr_req = 1'b0;
        wait_ack(1'b0, ok);
      end
    join
    chk(ok2 && s_ok, "R3 start bit", s_ok, 1);
    chk(b == 8'hA5, "R3 data", b, 8'hA5);
    chk(p_ok, "R3 stop bit", p_ok, 1);
    chk(shape == 0, "R2 R4 subcarrier shape", shape, 0);
    chk(ok, "R5 ack falls", wr_ack, 0);
    hi = 0;
    for (int i = 0; i < 3*BP; i++) begin if (load_mod !== 1'b0) hi++; @(negedge clk); end
    chk(hi == 0, "R4 idle low", hi, 0);
  endtask

  task automatic t_tx_back_to_back;
    bit ok, okm, s1, p1, s2, p2, hold; logic [7:0] b1, b2; int sh1, sh2;
    wr_data = 8'h0F; wr_req = 1'b1;
    wait_ack(1'b1, ok);
    fork
      begin
        wait_mod_high(okm);
        decode_frame(b1, s1, p1, sh1);
        decode_frame(b2, s2, p2, sh2);
      end
      begin
        wr_req = 1'b0;
        wait_ack(1'b0, ok);
        wr_data = 8'hC3; wr_req = 1'b1;
        wait_ack(1'b1, ok);
        wr_req = 1'b0;
        cycles(2*BP);
        hold = (wr_ack === 1'b1);
        wait_ack(1'b0, ok);
      end
    join
    chk(hold, "R5 ack held while buffer full", hold, 1);
    chk(ok, "R5 ack falls after hand-off", wr_ack, 0);
    chk(okm && b1 == 8'h0F && s1 && p1, "R3 first frame", b1, 8'h0F);
    chk(b2 == 8'hC3 && s2 && p2, "R3 second frame", b2, 8'hC3);
    chk(sh1 == 0 && sh2 == 0, "R4 modulation back to back", sh1 + sh2, 0);
  endtask

  task automatic t_write_ignored_rx;
    int bad = 0;
    rx_en = 1'b1; cycles(6);
    wr_data = 8'h77; wr_req = 1'b1;
    for (int i = 0; i < 30; i++) begin
      if (wr_ack !== 1'b0 || load_mod !== 1'b0) bad++;
      @(negedge clk);
    end
    wr_req = 1'b0; cycles(4);
    chk(bad == 0, "R6 write ignored in receive", bad, 0);
  endtask

  task automatic t_rx_basic;
    bit ok;
    rd_rdy = 1'b1; cycles(10);
    chk(rd_req === 1'b0, "R8 no request without byte", rd_req, 0);
    send_serial(8'h3C, 1'b1);
    wait_rdreq(1'b1, ok);
    chk(ok, "R8 request raised", rd_req, 1);
    chk(rd_data == 8'h3C, "R7 received byte", rd_data, 8'h3C);
    rd_rdy = 1'b0;
    wait_rdreq(1'b0, ok);
    chk(ok, "R8 request returns to zero", rd_req, 0);
    cycles(10);
    chk(rd_req === 1'b0, "R8 buffer freed", rd_req, 0);
  endtask

  task automatic t_rx_overrun;
    bit ok;
    rd_rdy = 1'b0;
    send_serial(8'h11, 1'b1);
    send_serial(8'h22, 1'b1);
    cycles(3*BP);
    chk(overrun === 1'b1, "R10 overrun set", overrun, 1);
    chk(rd_req === 1'b0, "R8 no request while not ready", rd_req, 0);
    rd_rdy = 1'b1;
    wait_rdreq(1'b1, ok);
    chk(ok && rd_data == 8'h22, "R10 newest byte kept", rd_data, 8'h22);
    rd_rdy = 1'b0;
    wait_rdreq(1'b0, ok);
    cycles(2);
    chk(overrun === 1'b0, "R10 overrun cleared by read", overrun, 0);
  endtask

  task automatic t_rx_framing;
    bit ok; int base;
    rd_rdy = 1'b1;
    base = ferr_cnt;
    send_serial(8'h5A, 1'b0);
    cycles(3*BP);
    chk(ferr_cnt - base == 1, "R9 single error pulse", ferr_cnt - base, 1);
    chk(rd_req === 1'b0, "R9 frame discarded", rd_req, 0);
    send_serial(8'h81, 1'b1);
    wait_rdreq(1'b1, ok);
    chk(ok && rd_data == 8'h81, "R7 recovery after error", rd_data, 8'h81);
    rd_rdy = 1'b0;
    wait_rdreq(1'b0, ok);
    chk(overrun === 1'b0, "R10 no overrun after discarded frame", overrun, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cycles(3);
    t_reset();
    rst_n = 1'b1;
    cycles(4);
    t_reset();
    t_tx_single();
    t_tx_back_to_back();
    t_write_ignored_rx();
    t_rx_basic();
    t_rx_overrun();
    t_rx_framing();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule